// File: doc/BRIEF.md
# DMA Completion Interrupt Collector

This block sits between a DMA engine and a processor. It merges the engine's transfer-completion reports into one interrupt line. Each report comes with the options word of the channel that finished. The options word holds a flag that asks for a completion interrupt, and a 6-bit completion code that software programs.

When the flag is set, the code picks one bit of a 64-bit pending vector and sets it. A completion code can be shared by several channels, so the pending bit says which kind of work finished, not which channel did it. A 64-bit mask vector decides which pending bits may raise the interrupt. The interrupt is a registered level.

Software uses a small write port to set or clear pending bits and mask bits, given as bit masks. It reads the pending vector, the mask vector, the code of the latest recorded completion and a saturating count of completions that landed on a bit that was already pending.

Top module: `dma_cmpl_irq`

## Requirements
- R1: After reset, the pending vector, the mask vector, the interrupt output, the overflow count and the last-code output are all zero.
- R2: A completion (`cmpl_vld`=1) whose options word has bit 20 set sets pending bit number `cmpl_opt[17:12]`, visible in the cycle after the report.
- R3: A completion whose options word has bit 20 clear leaves the pending vector, the overflow count and the last-code output unchanged.
- R4: A register write with `reg_op`=0 sets every pending bit that is 1 in `reg_wdata`. A write with `reg_op`=1 clears every pending bit that is 1 in `reg_wdata`.
- R5: If a recorded completion and a pending-clear write hit the same bit in the same cycle, that bit ends up set.
- R6: A write with `reg_op`=2 sets the mask bits given in `reg_wdata`, and a write with `reg_op`=3 clears them. No other input changes the mask vector.
- R7: `irq_o` is 1 in the cycle after any bit is 1 in both the pending and the mask vectors, and 0 in the cycle after no such bit remains.
- R8: `last_code_o` holds the completion code of the most recently recorded completion.
- R9: A recorded completion whose code selects a bit that is already pending, and that is not being cleared in the same cycle, adds one to `ovf_cnt_o`. The count stops at its maximum and is never cleared except by reset.
- R10: Options-word bits other than bit 20 and bits 17..12 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmpl_vld | input | 1 | Completion report strobe |
| cmpl_opt | input | 32 | Options word of the finished channel |
| reg_we | input | 1 | Register write strobe |
| reg_op | input | 2 | Write operation: 0 pending set, 1 pending clear, 2 mask set, 3 mask clear |
| reg_wdata | input | 64 | Bit mask for the write |
| pend_o | output | 64 | Pending vector |
| ien_o | output | 64 | Interrupt mask vector |
| irq_o | output | 1 | Global interrupt, registered level |
| last_code_o | output | 6 | Code of the latest recorded completion |
| ovf_cnt_o | output | CNT_W | Saturating overflow count |

## Verification
The bench builds the block with the full 64 codes and a 3-bit overflow count. With 64 codes, a sweep can record every completion code once, with non-code option bits varied, and then repeat the sweep with the enable flag clear. With a 3-bit count, saturation is reached after seven repeated hits on one bit. Masked and unmasked interrupts are compared against their one-cycle lag, and so is a completion that collides with a clear.

// File: rtl/dma_cmpl_irq.sv
module dma_cmpl_irq #(
  parameter int NCODE    = 64,
  parameter int CODE_W   = $clog2(NCODE),
  parameter int OPT_W    = 32,
  parameter int IEN_POS  = 20,
  parameter int CODE_LSB = 12,
  parameter int CNT_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmpl_vld,
  input  logic [OPT_W-1:0]  cmpl_opt,
  input  logic              reg_we,
  input  logic [1:0]        reg_op,
  input  logic [NCODE-1:0]  reg_wdata,
  output logic [NCODE-1:0]  pend_o,
  output logic [NCODE-1:0]  ien_o,
  output logic              irq_o,
  output logic [CODE_W-1:0] last_code_o,
  output logic [CNT_W-1:0]  ovf_cnt_o
);

  localparam logic [1:0] OP_PSET = 2'd0;
  localparam logic [1:0] OP_PCLR = 2'd1;
  localparam logic [1:0] OP_ESET = 2'd2;
  localparam logic [1:0] OP_ECLR = 2'd3;

  logic              hit;
  logic [CODE_W-1:0] code;
  logic [NCODE-1:0]  cmpl_vec, pset, pclr, eset, eclr;
  logic              dup;

  assign hit      = cmpl_vld & cmpl_opt[IEN_POS];
  assign code     = cmpl_opt[CODE_LSB +: CODE_W];
  assign cmpl_vec = hit ? (NCODE'(1) << code) : '0;

  assign pset = (reg_we && reg_op == OP_PSET) ? reg_wdata : '0;
  assign pclr = (reg_we && reg_op == OP_PCLR) ? reg_wdata : '0;
  assign eset = (reg_we && reg_op == OP_ESET) ? reg_wdata : '0;
  assign eclr = (reg_we && reg_op == OP_ECLR) ? reg_wdata : '0;

  assign dup = hit && pend_o[code] && !pclr[code];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_o      <= '0;
      ien_o       <= '0;
      irq_o       <= 1'b0;
      last_code_o <= '0;
      ovf_cnt_o   <= '0;
    end else begin
      pend_o <= (pend_o & ~pclr) | pset | cmpl_vec;
      ien_o  <= (ien_o | eset) & ~eclr;
      irq_o  <= |(pend_o & ien_o);
      if (hit) last_code_o <= code;
      if (dup && ovf_cnt_o != '1) ovf_cnt_o <= ovf_cnt_o + 1'b1;
    end
  end

endmodule

// File: rtl/dma_cmpl_irq_chk.sv
module dma_cmpl_irq_chk #(
  parameter int NCODE    = 64,
  parameter int CODE_W   = 6,
  parameter int OPT_W    = 32,
  parameter int IEN_POS  = 20,
  parameter int CODE_LSB = 12,
  parameter int CNT_W    = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmpl_vld,
  input logic [OPT_W-1:0]  cmpl_opt,
  input logic              reg_we,
  input logic [1:0]        reg_op,
  input logic [NCODE-1:0]  reg_wdata,
  input logic [NCODE-1:0]  pend_o,
  input logic [NCODE-1:0]  ien_o,
  input logic              irq_o,
  input logic [CODE_W-1:0] last_code_o,
  input logic [CNT_W-1:0]  ovf_cnt_o
);

  AST_CMPL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_vld && cmpl_opt[IEN_POS]) |=> pend_o[$past(cmpl_opt[CODE_LSB +: CODE_W])]); // R2

  AST_OFF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_vld && !cmpl_opt[IEN_POS] && !reg_we) |=> $stable(pend_o)); // R3

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_op == 2'd1 && !(cmpl_vld && cmpl_opt[IEN_POS])) |=> ((pend_o & $past(reg_wdata)) == '0)); // R4

  AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(ien_o)); // R6

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend_o & ien_o)) |=> irq_o); // R7

  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(pend_o & ien_o)) |=> !irq_o); // R7

  AST_NO_OVF_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ovf_cnt_o >= $past(ovf_cnt_o)); // R9

endmodule

bind dma_cmpl_irq dma_cmpl_irq_chk #(
  .NCODE(NCODE), .CODE_W(CODE_W), .OPT_W(OPT_W),
  .IEN_POS(IEN_POS), .CODE_LSB(CODE_LSB), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmpl_vld(cmpl_vld), .cmpl_opt(cmpl_opt),
  .reg_we(reg_we), .reg_op(reg_op), .reg_wdata(reg_wdata),
  .pend_o(pend_o), .ien_o(ien_o), .irq_o(irq_o),
  .last_code_o(last_code_o), .ovf_cnt_o(ovf_cnt_o)
);

// File: tb/tb_dma_cmpl_irq.sv
module tb_dma_cmpl_irq;
  localparam int CW = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmpl_vld = 1'b0;
  logic [31:0] cmpl_opt = '0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_op = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] pend_o, ien_o;
  logic        irq_o;
  logic [5:0]  last_code_o;
  logic [CW-1:0] ovf_cnt_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [63:0]   e_pend = '0, e_en = '0;
  logic          e_irq = 1'b0;
  logic [5:0]    e_last = '0;
  logic [CW-1:0] e_cnt = '0;

  always #10 clk = ~clk;

  dma_cmpl_irq #(.CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .cmpl_vld(cmpl_vld), .cmpl_opt(cmpl_opt),
    .reg_we(reg_we), .reg_op(reg_op), .reg_wdata(reg_wdata),
    .pend_o(pend_o), .ien_o(ien_o), .irq_o(irq_o),
    .last_code_o(last_code_o), .ovf_cnt_o(ovf_cnt_o)
  );

  task automatic cmp(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    cmp({req, " pend"}, pend_o, e_pend);
    cmp({req, " mask"}, ien_o, e_en);
    cmp({req, " irq R7"}, 64'(irq_o), 64'(e_irq));
    cmp({req, " last R8"}, 64'(last_code_o), 64'(e_last));
    cmp({req, " ovf R9"}, 64'(ovf_cnt_o), 64'(e_cnt));
  endtask

  task automatic apply(input logic vld, input logic [31:0] opt, input logic we,
                       input logic [1:0] op, input logic [63:0] data, input string req);
    logic hit;
    logic [5:0] c;
    logic [63:0] sv, cv;
    hit = vld & opt[20];
    c   = opt[17:12];
    sv  = (hit ? (64'd1 << c) : 64'd0) | ((we && op == 2'd0) ? data : 64'd0);
    cv  = (we && op == 2'd1) ? data : 64'd0;
    e_irq = |(e_pend & e_en);
    if (hit && e_pend[c] && !cv[c] && e_cnt != '1) e_cnt = e_cnt + 1'b1;
    if (hit) e_last = c;
    e_pend = (e_pend & ~cv) | sv;
    if (we && op == 2'd2) e_en = e_en | data;
    if (we && op == 2'd3) e_en = e_en & ~data;
    cmpl_vld = vld; cmpl_opt = opt; reg_we = we; reg_op = op; reg_wdata = data;
    @(posedge clk); #2;
    cmpl_vld = 1'b0; cmpl_opt = '0; reg_we = 1'b0; reg_op = '0; reg_wdata = '0;
    check_all(req);
  endtask

  function automatic logic [31:0] mkopt(input logic en, input logic [5:0] c, input int salt);
    logic [31:0] junk;
    junk = (32'hA5C3_5A3C ^ (32'(salt) * 32'h0101_0107)) & ~32'h0013_F000;
    return junk | (32'(en) << 20) | (32'(c) << 12);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    check_all("R1 reset");

    for (int c = 0; c < 64; c++) apply(1'b1, mkopt(1'b1, 6'(c), c), 1'b0, 2'd0, '0, "R2 R10 sweep");
    apply(1'b0, '0, 1'b1, 2'd1, '1, "R4 clear all");
    for (int c = 0; c < 64; c++) apply(1'b1, mkopt(1'b0, 6'(c), c + 7), 1'b0, 2'd0, '0, "R3 flag off");
    apply(1'b0, '0, 1'b1, 2'd0, 64'h8000_0000_0001_0100, "R4 sw set");
    apply(1'b0, '0, 1'b1, 2'd1, 64'h8000_0000_0001_0100, "R4 sw clear");

    apply(1'b0, '0, 1'b1, 2'd2, 64'h20, "R6 mask set");
    apply(1'b0, '0, 1'b1, 2'd0, 64'h80, "R7 masked pend");
    apply(1'b0, '0, 1'b0, 2'd0, '0, "R7 masked idle");
    apply(1'b1, mkopt(1'b1, 6'd5, 3), 1'b0, 2'd0, '0, "R7 cmpl unmasked");
    apply(1'b0, '0, 1'b0, 2'd0, '0, "R7 rise");
    apply(1'b0, '0, 1'b1, 2'd1, 64'h20, "R7 clear last");
    apply(1'b0, '0, 1'b0, 2'd0, '0, "R7 fall");
    apply(1'b0, '0, 1'b1, 2'd2, '1, "R6 mask all");
    apply(1'b0, '0, 1'b0, 2'd0, '0, "R7 rise via mask");
    apply(1'b1, mkopt(1'b0, 6'd40, 9), 1'b0, 2'd0, '0, "R6 cmpl no mask effect");
    apply(1'b0, '0, 1'b1, 2'd3, 64'hFFFF_0000_FFFF_FF7F, "R6 mask clear");
    apply(1'b0, '0, 1'b1, 2'd3, 64'h80, "R7 mask clear fall");
    apply(1'b0, '0, 1'b0, 2'd0, '0, "R7 masked off");

    apply(1'b1, mkopt(1'b1, 6'd9, 11), 1'b0, 2'd0, '0, "R2 set 9");
    apply(1'b1, mkopt(1'b1, 6'd9, 12), 1'b1, 2'd1, 64'h200, "R5 collide");
    cmp("R5 bit kept", 64'(pend_o[9]), 64'd1);
    for (int k = 0; k < 10; k++) apply(1'b1, mkopt(1'b1, 6'd9, 20 + k), 1'b0, 2'd0, '0, "R9 repeat");
    cmp("R9 saturated", 64'(ovf_cnt_o), 64'd7);
    apply(1'b0, '0, 1'b1, 2'd1, '1, "R9 clear keeps count");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule